// File: doc/BRIEF.md
# Four-Channel DMA Fixed-Priority Grant Arbiter

This block decides which of four DMA channels owns the system bus. Each channel presents a request line and a two-bit transfer mode. The block drives a one-hot grant vector. A channel's transfer unit can end in one of two ways:

- in cycle-steal mode, at every completed bus transfer;
- in burst or block mode, only at the transfer that is flagged as the end of the burst or block.

When a unit ends and another channel is waiting, the grant is withdrawn for exactly one cycle. That slot goes to a competing non-DMA bus master if it asked for the bus. Otherwise the bus sits idle for that cycle. After the gap, the highest-priority waiting channel other than the one that just ran takes over.

The surrounding DMA engine supplies the per-transfer done strobe and the end-of-segment flag. Address generation, counting and the data path live in that engine, not here. Requests are sampled live each cycle and are never stored, so a request that drops before it is served leaves no trace.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted and after its release with no requests, `gnt_o` and `ext_gnt_o` are all zero.
- R2: From idle, the cycle after any request is seen, the grant goes to the lowest-numbered requesting channel (channel 0 highest, channel 3 lowest).
- R3: `gnt_o` is always one-hot or all-zero.
- R4: When a transfer unit ends and some other channel is requesting, the next channel granted is the lowest-numbered requester excluding the channel that just ran.
- R5: A change from one channel to another always passes through exactly one cycle with `gnt_o` all zero; a grant never moves directly between channels.
- R6: `ext_gnt_o` is high for that single gap cycle exactly when `ext_req_i` was high in the cycle the unit ended, and it is never high while any channel is granted.
- R7: With `ext_req_i` low, the gap is one idle cycle and the new channel is granted in the very next cycle.
- R8: A channel in burst mode (mode code 2'b01) keeps the grant across done strobes until a done strobe arrives with `seg_end_i` high.
- R9: A channel in block mode (mode code 2'b10) keeps the grant across done strobes until a done strobe arrives with `seg_end_i` high.
- R10: A channel in cycle-steal mode (mode code 2'b00; 2'b11 behaves the same) ends its unit on every done strobe.
- R11: If, when a unit ends, the current channel is the only requester, it keeps the grant with no gap cycle.
- R12: If no channel requests when a unit ends, or no request remains at the end of a gap, the grant falls to zero and the arbiter goes idle. A request withdrawn before it is granted has no later effect.
- R13: While a channel is granted, the grant does not change in any cycle without a done strobe, whatever the other requests do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH (4) | Per-channel transfer request, bit i for channel i |
| mode_i | input | 2*NCH (8) | Per-channel mode, bits [2i+1:2i]: 00 cycle steal, 01 burst, 10 block, 11 as cycle steal |
| xfer_done_i | input | 1 | The granted channel completed one bus transfer this cycle |
| seg_end_i | input | 1 | Qualifies `xfer_done_i` as the last transfer of a burst or block |
| ext_req_i | input | 1 | Another bus master wants the bus |
| gnt_o | output | NCH (4) | One-hot channel grant, registered |
| ext_gnt_o | output | 1 | One-cycle bus slot for the other master during a channel switch |

## Verification
Priority from idle is tried with several request sets: all four channels, the top three, the top two, the lowest alone, and a sparse pair. Together these show that the encoder scans from channel 0 downwards and does not favour a fixed bit.

Switch sequences use request sets in which the finished channel is, or is not, the highest requester. This separates an exclusion of the previous channel from a plain re-arbitration. Runs with `ext_req_i` high and low separate the handed-over gap from the idle gap.

Burst and block runs keep a higher-priority channel requesting across several non-final done strobes, so any premature switch would show. Requests that are withdrawn during a gap, or pulsed while another channel holds the bus, confirm that nothing is latched.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'b00,
        ARB_XFER = 2'b01,
        ARB_GAP  = 2'b10
    } arb_state_e;

    typedef enum logic [1:0] {
        XM_STEAL = 2'b00,
        XM_BURST = 2'b01,
        XM_BLOCK = 2'b10,
        XM_RSVD  = 2'b11
    } xfer_mode_e;

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req_i,
    output logic           any_o,
    output logic [IW-1:0]  idx_o
);

    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/dma_unit_end.sv
module dma_unit_end
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [2*NCH-1:0] mode_i,
    input  logic [IW-1:0]    cur_i,
    input  logic             done_i,
    input  logic             seg_end_i,
    output xfer_mode_e       cur_mode_o,
    output logic             unit_end_o
);

    logic [1:0] mode_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_mode
        assign mode_a[g] = mode_i[2*g +: 2];
    end

    always_comb begin
        cur_mode_o = xfer_mode_e'(mode_a[cur_i]);
        unique case (cur_mode_o)
            XM_BURST, XM_BLOCK: unit_end_o = done_i && seg_end_i;
            default:            unit_end_o = done_i;
        endcase
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_i,
    input  logic [2*NCH-1:0] mode_i,
    input  logic             xfer_done_i,
    input  logic             seg_end_i,
    input  logic             ext_req_i,
    output logic [NCH-1:0]   gnt_o,
    output logic             ext_gnt_o
);

    typedef struct packed {
        arb_state_e     state;
        logic [IW-1:0]  cur;
        logic [NCH-1:0] gnt;
        logic           ext_gnt;
    } arb_regs_t;

    localparam arb_regs_t REGS_RST = '{state: ARB_IDLE, cur: '0, gnt: '0, ext_gnt: 1'b0};

    arb_regs_t r_q, r_d;

    logic [NCH-1:0] cur_mask;
    logic           any_all, any_oth;
    logic [IW-1:0]  idx_all, idx_oth;
    xfer_mode_e     cur_mode;
    logic           unit_end;

    assign cur_mask = NCH'(1) << r_q.cur;

    dma_prio_pick #(.NCH(NCH)) u_pick_all (
        .req_i (req_i),
        .any_o (any_all),
        .idx_o (idx_all)
    );

    dma_prio_pick #(.NCH(NCH)) u_pick_oth (
        .req_i (req_i & ~cur_mask),
        .any_o (any_oth),
        .idx_o (idx_oth)
    );

    dma_unit_end #(.NCH(NCH)) u_unit_end (
        .mode_i     (mode_i),
        .cur_i      (r_q.cur),
        .done_i     (xfer_done_i),
        .seg_end_i  (seg_end_i),
        .cur_mode_o (cur_mode),
        .unit_end_o (unit_end)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ext_gnt = 1'b0;
        unique case (r_q.state)
            ARB_IDLE: begin
                if (any_all) begin
                    r_d.state = ARB_XFER;
                    r_d.cur   = idx_all;
                    r_d.gnt   = NCH'(1) << idx_all;
                end
            end
            ARB_XFER: begin
                if (unit_end) begin
                    if (any_oth) begin
                        r_d.state   = ARB_GAP;
                        r_d.gnt     = '0;
                        r_d.ext_gnt = ext_req_i;
                    end else if (!req_i[r_q.cur]) begin
                        r_d.state = ARB_IDLE;
                        r_d.gnt   = '0;
                    end
                end
            end
            ARB_GAP: begin
                if (any_oth) begin
                    r_d.state = ARB_XFER;
                    r_d.cur   = idx_oth;
                    r_d.gnt   = NCH'(1) << idx_oth;
                end else if (req_i[r_q.cur]) begin
                    r_d.state = ARB_XFER;
                    r_d.gnt   = cur_mask;
                end else begin
                    r_d.state = ARB_IDLE;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign gnt_o     = r_q.gnt;
    assign ext_gnt_o = r_q.ext_gnt;

    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2
    idle_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ARB_IDLE && req_i != '0) |=> (gnt_o != '0));

    // R5
    no_direct_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |=> (gnt_o == '0 || $stable(gnt_o)));

    // R6
    ext_gap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt_o |-> (gnt_o == '0));

    // R6
    ext_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_gnt_o |=> !ext_gnt_o);

    // R8 R9
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && xfer_done_i && !seg_end_i &&
         (cur_mode == XM_BURST || cur_mode == XM_BLOCK)) |=> $stable(gnt_o));

    // R13
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !xfer_done_i) |=> $stable(gnt_o));

    // R12
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && unit_end && req_i == '0) |=> (gnt_o == '0));

endmodule

// File: tb/sim_dma_prio_arb.sv
module sim_dma_prio_arb;

    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   req;
    logic [2*NCH-1:0] mode;
    logic             done, seg, ext_req;
    logic [NCH-1:0]   gnt;
    logic             ext_gnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_prio_arb #(.NCH(NCH)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .mode_i      (mode),
        .xfer_done_i (done),
        .seg_end_i   (seg),
        .ext_req_i   (ext_req),
        .gnt_o       (gnt),
        .ext_gnt_o   (ext_gnt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        req = '0; done = 1'b1; seg = 1'b1; ext_req = 1'b0;
        tick();
        done = 1'b0; seg = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = '0; mode = '0; done = 1'b0; seg = 1'b0; ext_req = 1'b0;
        tick(); tick();
        check("R1 gnt in reset", 32'(gnt), 0);
        check("R1 ext_gnt in reset", 32'(ext_gnt), 0);
        rst_n = 1'b1;
        tick();
        check("R1 gnt after reset", 32'(gnt), 0);
    endtask

    task automatic t_priority();
        logic [3:0] pat [5] = '{4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b1010};
        logic [3:0] exp [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0010};
        for (int k = 0; k < 5; k++) begin
            req = pat[k];
            tick();
            check("R2 idle priority", 32'(gnt), 32'(exp[k]));
            check("R3 onehot", 32'($countones(gnt) <= 1), 1);
            go_idle();
            check("R12 back to idle", 32'(gnt), 0);
        end
    endtask

    task automatic t_switch();
        mode = '0; req = 4'b0111;
        tick();
        check("R2 first grant", 32'(gnt), 32'h1);
        done = 1'b1;
        tick();
        check("R5 R10 gap after steal", 32'(gnt), 0);
        check("R7 idle gap no ext", 32'(ext_gnt), 0);
        done = 1'b0;
        tick();
        check("R4 R7 next excludes ch0", 32'(gnt), 32'h2);
        req = 4'b0011; done = 1'b1;
        tick();
        check("R5 gap", 32'(gnt), 0);
        done = 1'b0;
        tick();
        check("R4 ch0 after ch1", 32'(gnt), 32'h1);
        req = 4'b0101; done = 1'b1;
        tick();
        done = 1'b0;
        tick();
        check("R4 ch2 since ch0 excluded", 32'(gnt), 32'h4);
        go_idle();
    endtask

    task automatic t_ext();
        req = 4'b0011;
        tick();
        check("R2 ch0", 32'(gnt), 32'h1);
        ext_req = 1'b1; done = 1'b1;
        tick();
        check("R6 ext slot", 32'(ext_gnt), 1);
        check("R6 gnt zero in slot", 32'(gnt), 0);
        done = 1'b0;
        tick();
        check("R6 ext slot one cycle", 32'(ext_gnt), 0);
        check("R6 new channel after slot", 32'(gnt), 32'h2);
        go_idle();
    endtask

    task automatic t_burst();
        mode = 8'b00_00_01_00; req = 4'b0010;
        tick();
        check("R8 burst grant", 32'(gnt), 32'h2);
        req = 4'b0011; done = 1'b1; seg = 1'b0;
        tick();
        check("R8 burst held 1", 32'(gnt), 32'h2);
        tick();
        check("R8 burst held 2", 32'(gnt), 32'h2);
        seg = 1'b1;
        tick();
        check("R8 burst end gap", 32'(gnt), 0);
        done = 1'b0; seg = 1'b0;
        tick();
        check("R8 after burst ch0", 32'(gnt), 32'h1);
        go_idle();
        mode = '0;
    endtask

    task automatic t_block();
        mode = 8'b00_10_00_00; req = 4'b0100;
        tick();
        check("R9 block grant", 32'(gnt), 32'h4);
        req = 4'b1101; done = 1'b1; seg = 1'b0;
        tick();
        check("R9 block held 1", 32'(gnt), 32'h4);
        tick();
        check("R9 block held 2", 32'(gnt), 32'h4);
        seg = 1'b1;
        tick();
        check("R9 block end gap", 32'(gnt), 0);
        done = 1'b0; seg = 1'b0;
        tick();
        check("R9 after block ch0", 32'(gnt), 32'h1);
        go_idle();
        mode = '0;
    endtask

    task automatic t_hold();
        req = 4'b1000;
        tick();
        check("R2 ch3 alone", 32'(gnt), 32'h8);
        req = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R13 hold without done", 32'(gnt), 32'h8);
        end
        go_idle();
    endtask

    task automatic t_sole();
        req = 4'b0100;
        tick();
        check("R2 ch2 alone", 32'(gnt), 32'h4);
        done = 1'b1;
        tick();
        check("R11 regrant no gap", 32'(gnt), 32'h4);
        tick();
        check("R11 regrant again", 32'(gnt), 32'h4);
        done = 1'b0;
        go_idle();
    endtask

    task automatic t_withdraw();
        req = 4'b0011;
        tick();
        done = 1'b1;
        tick();
        check("R5 gap before switch", 32'(gnt), 0);
        done = 1'b0; req = 4'b0001;
        tick();
        check("R12 withdrawn ch1 ignored", 32'(gnt), 32'h1);
        go_idle();
        req = 4'b1000;
        tick();
        req = 4'b1010;
        tick();
        req = 4'b1000;
        tick();
        req = 4'b0000; done = 1'b1;
        tick();
        check("R12 idle at end", 32'(gnt), 0);
        done = 1'b0;
        tick();
        check("R12 pulse not latched", 32'(gnt), 0);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_switch();
        t_ext();
        t_burst();
        t_block();
        t_hold();
        t_sole();
        t_withdraw();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule